// File: doc/BRIEF.md
# Event Ring Producer with Interrupt

This device-side block posts event records into a circular ring kept in host memory. Sources inside the device present an event on a valid/ready handshake: transfer completions, command completions and state changes. Each event carries a type, a channel number, a completion code and a 64-bit pointer to the element it reports on. The block writes the record to the ring slot named by its read pointer through a single memory-write port. Once the write is acknowledged, it steps the read pointer and pulses an interrupt line for one cycle.

The host tells the block how far it has consumed the ring by writing a new value into the block's copy of the write pointer through a register port. The pointer senses are the reverse of a work-queue ring. Equal pointers mean the ring is full of unread events. The ring is drained when the write pointer plus one, wrapped, equals the read pointer. A ring of 2^PTR_W slots therefore holds at most 2^PTR_W - 1 unread events. When the ring is full, the block withholds ready from the event source and writes nothing.

Top module: `evr_producer`

## Requirements
- R1: After reset the read pointer is 0, the write pointer is 2^PTR_W - 1, ring_empty is 1, ring_full is 0, and evt_ready is 1. mem_wr_valid and irq_pulse are both 0.
- R2: ring_full is 1 exactly when dev_rp equals dev_wp. ring_empty is 1 exactly when dev_wp + 1, modulo 2^PTR_W, equals dev_rp. Both flags follow the registered pointers.
- R3: While ring_full is 1, evt_ready is 0, and an offered event is neither accepted nor written.
- R4: An event accepted on a rising edge drives mem_wr_valid from the next cycle, with mem_wr_idx equal to the read pointer at acceptance. The record layout is mem_wr_data[87:80] type, [79:72] channel, [71:64] completion code and [63:0] element pointer. Index and data hold steady until mem_wr_ack.
- R5: On each edge where mem_wr_valid and mem_wr_ack are both 1, dev_rp advances by one, wrapping at 2^PTR_W. At no other time does dev_rp change, except at reset.
- R6: irq_pulse is 1 for exactly the one cycle that follows an acknowledged write, and is 0 at all other times.
- R7: A host write (host_wp_we = 1) loads host_wp_val into dev_wp on the same edge. If that edge also acknowledges a write, both pointer updates take effect.
- R8: At most one event is in flight: evt_ready is 0 while mem_wr_valid is 1. evt_ready may return in the cycle after the acknowledge.
- R9: Event type codes are 8'h01 for transfer completion, 8'h02 for command completion and 8'h03 for state change. They are carried to the record unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Event offered |
| evt_ready | output | 1 | Event accepted when high together with evt_valid |
| evt_type | input | 8 | Event type code |
| evt_chan | input | 8 | Channel number |
| evt_code | input | 8 | Completion code |
| evt_elem_ptr | input | 64 | Pointer to the completed element |
| mem_wr_valid | output | 1 | Ring slot write request |
| mem_wr_idx | output | PTR_W | Ring slot index |
| mem_wr_data | output | 88 | Event record |
| mem_wr_ack | input | 1 | Write acknowledged |
| host_wp_we | input | 1 | Host write-pointer update strobe |
| host_wp_val | input | PTR_W | New write-pointer value |
| dev_rp | output | PTR_W | Device read pointer |
| dev_wp | output | PTR_W | Device copy of the write pointer |
| ring_full | output | 1 | Ring holds 2^PTR_W - 1 unread events |
| ring_empty | output | 1 | Ring holds no unread events |
| irq_pulse | output | 1 | One-cycle interrupt after a completed write |

## Verification
Two things can land on the same edge: the read pointer advancing when a write is acknowledged, and the host loading a new write pointer. A long random phase drives the acknowledge and host consumption independently, so the two coincide many times. The bench counts those coincidences and requires at least one. In every cycle, a behavioural model built on integers and a queue of pending records is compared with both pointers and both ring flags. A fill phase with no consumption drives the ring to full, so that back-pressure and the inverted flags are checked at the boundary.

// File: rtl/evr_pkg.sv
package evr_pkg;

    typedef enum logic [7:0] {
        EVK_XFER_DONE = 8'h01,
        EVK_CMD_DONE  = 8'h02,
        EVK_STATE_CHG = 8'h03
    } evt_kind_e;

    typedef struct packed {
        logic [7:0]  kind;
        logic [7:0]  chan;
        logic [7:0]  code;
        logic [63:0] elem_ptr;
    } evt_rec_t;

    localparam int REC_W = $bits(evt_rec_t);

    typedef enum logic {
        PS_IDLE  = 1'b0,
        PS_WRITE = 1'b1
    } post_state_e;

    function automatic evt_rec_t make_rec(
        input logic [7:0]  kind,
        input logic [7:0]  chan,
        input logic [7:0]  code,
        input logic [63:0] elem_ptr
    );
        evt_rec_t r;
        r.kind     = kind;
        r.chan     = chan;
        r.code     = code;
        r.elem_ptr = elem_ptr;
        return r;
    endfunction

endpackage

// File: rtl/evr_ptr_track.sv
module evr_ptr_track #(
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             host_we,
    input  logic [PTR_W-1:0] host_val,
    output logic [PTR_W-1:0] rp,
    output logic [PTR_W-1:0] wp,
    output logic             full,
    output logic             empty
);

    logic [PTR_W-1:0] wp_plus1;
    logic [PTR_W-1:0] rp_plus1;

    assign wp_plus1 = wp + 1'b1;
    assign rp_plus1 = rp + 1'b1;

    // Device pointer: moves only on a completed write.
    always_ff @(posedge clk) begin
        if (rst) begin
            rp <= '0;
        end else if (adv) begin
            rp <= rp_plus1;
        end
    end

    // Host pointer copy: independent register, so both can update at once.
    always_ff @(posedge clk) begin
        if (rst) begin
            wp <= '1;
        end else if (host_we) begin
            wp <= host_val;
        end
    end

    // Inverted ring senses: equal means full, wp+1 == rp means drained.
    assign full  = (rp == wp);
    assign empty = (wp_plus1 == rp);

endmodule

// File: rtl/evr_post_fsm.sv
module evr_post_fsm
    import evr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     evt_valid,
    input  evt_rec_t rec_in,
    input  logic     ring_full,
    input  logic     mem_wr_ack,
    output logic     evt_ready,
    output logic     mem_wr_valid,
    output evt_rec_t rec_out,
    output logic     adv,
    output logic     irq_pulse
);

    post_state_e state;
    evt_rec_t    rec_q;
    logic        accept;
    logic        done;

    assign evt_ready    = (state == PS_IDLE) && !ring_full;
    assign accept       = evt_valid && evt_ready;
    assign mem_wr_valid = (state == PS_WRITE);
    assign done         = mem_wr_valid && mem_wr_ack;
    assign adv          = done;
    assign rec_out      = rec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PS_IDLE;
        end else begin
            unique case (state)
                PS_IDLE:  if (accept) state <= PS_WRITE;
                PS_WRITE: if (done)   state <= PS_IDLE;
                default:              state <= PS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q <= '0;
        end else if (accept) begin
            rec_q <= rec_in;
        end
    end

    // Interrupt follows the acknowledged write by one register.
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_pulse <= 1'b0;
        end else begin
            irq_pulse <= done;
        end
    end

endmodule

// File: rtl/evr_producer.sv
module evr_producer
    import evr_pkg::*;
#(
    parameter int PTR_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               evt_valid,
    output logic               evt_ready,
    input  logic [7:0]         evt_type,
    input  logic [7:0]         evt_chan,
    input  logic [7:0]         evt_code,
    input  logic [63:0]        evt_elem_ptr,
    output logic               mem_wr_valid,
    output logic [PTR_W-1:0]   mem_wr_idx,
    output logic [REC_W-1:0]   mem_wr_data,
    input  logic               mem_wr_ack,
    input  logic               host_wp_we,
    input  logic [PTR_W-1:0]   host_wp_val,
    output logic [PTR_W-1:0]   dev_rp,
    output logic [PTR_W-1:0]   dev_wp,
    output logic               ring_full,
    output logic               ring_empty,
    output logic               irq_pulse
);

    evt_rec_t rec_in;
    evt_rec_t rec_out;
    logic     adv;

    assign rec_in = make_rec(evt_type, evt_chan, evt_code, evt_elem_ptr);

    evr_ptr_track #(.PTR_W(PTR_W)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .adv      (adv),
        .host_we  (host_wp_we),
        .host_val (host_wp_val),
        .rp       (dev_rp),
        .wp       (dev_wp),
        .full     (ring_full),
        .empty    (ring_empty)
    );

    evr_post_fsm u_post (
        .clk          (clk),
        .rst          (rst),
        .evt_valid    (evt_valid),
        .rec_in       (rec_in),
        .ring_full    (ring_full),
        .mem_wr_ack   (mem_wr_ack),
        .evt_ready    (evt_ready),
        .mem_wr_valid (mem_wr_valid),
        .rec_out      (rec_out),
        .adv          (adv),
        .irq_pulse    (irq_pulse)
    );

    // The read pointer cannot move while a write is pending, so it names the slot.
    assign mem_wr_idx  = dev_rp;
    assign mem_wr_data = rec_out;

endmodule

// File: rtl/evr_producer_chk.sv
module evr_producer_chk #(
    parameter int PTR_W = 3,
    parameter int REC_W = 88
) (
    input logic             clk,
    input logic             rst,
    input logic             evt_valid,
    input logic             evt_ready,
    input logic             mem_wr_valid,
    input logic [PTR_W-1:0] mem_wr_idx,
    input logic [REC_W-1:0] mem_wr_data,
    input logic             mem_wr_ack,
    input logic             host_wp_we,
    input logic [PTR_W-1:0] host_wp_val,
    input logic [PTR_W-1:0] dev_rp,
    input logic [PTR_W-1:0] dev_wp,
    input logic             ring_full,
    input logic             ring_empty,
    input logic             irq_pulse
);

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(ring_full && ring_empty)); // R2

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        ring_full |-> !evt_ready); // R3

    AST_ACCEPT_WRITES: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_ready) |=> (mem_wr_valid && mem_wr_idx == $past(dev_rp))); // R4

    AST_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && !mem_wr_ack) |=>
            (mem_wr_valid && $stable(mem_wr_idx) && $stable(mem_wr_data))); // R4

    AST_RP_STEPS: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && mem_wr_ack) |=> (dev_rp == PTR_W'($past(dev_rp) + 1'b1))); // R5

    AST_RP_STILL: assert property (@(posedge clk) disable iff (rst)
        !(mem_wr_valid && mem_wr_ack) |=> $stable(dev_rp)); // R5

    AST_IRQ_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> $past(mem_wr_valid && mem_wr_ack)); // R6

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |=> !irq_pulse); // R6

    AST_WP_LOADS: assert property (@(posedge clk) disable iff (rst)
        host_wp_we |=> (dev_wp == $past(host_wp_val))); // R7

    AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (rst)
        mem_wr_valid |-> !evt_ready); // R8

endmodule

bind evr_producer evr_producer_chk #(.PTR_W(PTR_W), .REC_W(evr_pkg::REC_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .evt_valid    (evt_valid),
    .evt_ready    (evt_ready),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_idx   (mem_wr_idx),
    .mem_wr_data  (mem_wr_data),
    .mem_wr_ack   (mem_wr_ack),
    .host_wp_we   (host_wp_we),
    .host_wp_val  (host_wp_val),
    .dev_rp       (dev_rp),
    .dev_wp       (dev_wp),
    .ring_full    (ring_full),
    .ring_empty   (ring_empty),
    .irq_pulse    (irq_pulse)
);

// File: tb/evr_producer_tb.sv
module evr_producer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int PTR_W      = 3;
    localparam int DEPTH      = 1 << PTR_W;
    localparam int REC_W      = 88;
    localparam int WATCHDOG   = 50000;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               evt_valid = 1'b0;
    logic               evt_ready;
    logic [7:0]         evt_type = 8'h01;
    logic [7:0]         evt_chan = 8'h00;
    logic [7:0]         evt_code = 8'h00;
    logic [63:0]        evt_elem_ptr = 64'h0;
    logic               mem_wr_valid;
    logic [PTR_W-1:0]   mem_wr_idx;
    logic [REC_W-1:0]   mem_wr_data;
    logic               mem_wr_ack = 1'b0;
    logic               host_wp_we = 1'b0;
    logic [PTR_W-1:0]   host_wp_val = '0;
    logic [PTR_W-1:0]   dev_rp;
    logic [PTR_W-1:0]   dev_wp;
    logic               ring_full;
    logic               ring_empty;
    logic               irq_pulse;

    always #(CLK_PERIOD/2) clk = ~clk;

    evr_producer #(.PTR_W(PTR_W)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .evt_valid    (evt_valid),
        .evt_ready    (evt_ready),
        .evt_type     (evt_type),
        .evt_chan     (evt_chan),
        .evt_code     (evt_code),
        .evt_elem_ptr (evt_elem_ptr),
        .mem_wr_valid (mem_wr_valid),
        .mem_wr_idx   (mem_wr_idx),
        .mem_wr_data  (mem_wr_data),
        .mem_wr_ack   (mem_wr_ack),
        .host_wp_we   (host_wp_we),
        .host_wp_val  (host_wp_val),
        .dev_rp       (dev_rp),
        .dev_wp       (dev_wp),
        .ring_full    (ring_full),
        .ring_empty   (ring_empty),
        .irq_pulse    (irq_pulse)
    );

    // Behavioural reference state
    int               m_rp, m_wp;
    bit               m_busy, m_irq;
    logic [REC_W-1:0] m_q[$];
    int               n_checks = 0;
    int               n_fail   = 0;
    int               n_coincide = 0;
    int               n_full_seen = 0;
    int               n_writes = 0;
    int               cycles = 0;
    bit               finished = 1'b0;

    function automatic bit m_full();
        return m_rp == m_wp;
    endfunction
    function automatic bit m_empty();
        return ((m_wp + 1) % DEPTH) == m_rp;
    endfunction
    function automatic int m_pending();
        return (m_rp - m_wp - 1 + 2*DEPTH) % DEPTH;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [REC_W-1:0] act,
                       input logic [REC_W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cycles, act, exp);
        end
    endtask

    // Reference model update on each rising edge, from the inputs only.
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_rp = 0; m_wp = DEPTH - 1; m_busy = 0; m_irq = 0;
            m_q.delete();
        end else begin
            bit acc, done;
            acc  = evt_valid && !m_busy && !m_full();
            done = m_busy && mem_wr_ack;
            m_irq = done;
            if (done) begin
                m_rp = (m_rp + 1) % DEPTH;
                m_busy = 0;
                void'(m_q.pop_front());
                n_writes++;
                if (host_wp_we) n_coincide++;
            end
            if (acc) begin
                m_busy = 1;
                m_q.push_back({evt_type, evt_chan, evt_code, evt_elem_ptr});
            end
            if (host_wp_we) m_wp = int'(host_wp_val);
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(ring_full  == m_full(),  "R2 full flag",  ring_full,  m_full());
            chk(ring_empty == m_empty(), "R2 empty flag", ring_empty, m_empty());
            chk(evt_ready == (!m_busy && !m_full()), "R3/R8 ready", evt_ready, !m_busy && !m_full());
            chk(mem_wr_valid == m_busy, "R4 write valid", mem_wr_valid, m_busy);
            if (m_busy) begin
                chk(int'(mem_wr_idx) == m_rp, "R4 write index", mem_wr_idx, m_rp);
                chk(mem_wr_data == m_q[0], "R4 record layout", mem_wr_data, m_q[0]);
            end
            chk(int'(dev_rp) == m_rp, "R5 read pointer", dev_rp, m_rp);
            chk(irq_pulse == m_irq, "R6 interrupt", irq_pulse, m_irq);
            chk(int'(dev_wp) == m_wp, "R7 write pointer", dev_wp, m_wp);
            if (m_full()) n_full_seen++;
        end
    end

    task automatic drive_event();
        int k;
        k = $urandom_range(0, 2);
        evt_type     = (k == 0) ? 8'h01 : (k == 1) ? 8'h02 : 8'h03;  // R9 type codes
        evt_chan     = 8'($urandom);
        evt_code     = 8'($urandom);
        evt_elem_ptr = {32'($urandom), 32'($urandom)};
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired: actual %0d cycles expected fewer than %0d",
                     WATCHDOG, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(dev_rp == '0, "R1 rp reset", dev_rp, 0);
        chk(dev_wp == '1, "R1 wp reset", dev_wp, DEPTH - 1);
        chk(ring_empty && !ring_full, "R1 flags reset", {ring_full, ring_empty}, 2'b01);
        chk(evt_ready && !mem_wr_valid && !irq_pulse, "R1 handshake reset",
            {evt_ready, mem_wr_valid, irq_pulse}, 3'b100);

        // Fill: immediate acknowledge, no consumption, ring must stall at full (R3)
        mem_wr_ack = 1'b1;
        evt_valid  = 1'b1;
        for (int i = 0; i < 30; i++) begin
            drive_event();
            @(negedge clk);
        end
        chk(ring_full && !evt_ready, "R3 full stalls", {ring_full, evt_ready}, 2'b10);
        chk(n_writes == DEPTH - 1, "R3 capacity", n_writes, DEPTH - 1);

        // Host consumes everything in one write: ring drains (R2, R7)
        evt_valid   = 1'b0;
        host_wp_we  = 1'b1;
        host_wp_val = PTR_W'(m_rp - 1);
        @(negedge clk);
        host_wp_we = 1'b0;
        chk(ring_empty, "R2 drained after host write", ring_empty, 1);

        // Random phase: events, acknowledges and consumption overlap (R7, R8)
        for (int i = 0; i < 3000; i++) begin
            evt_valid  = ($urandom_range(0, 9) < 7);
            drive_event();
            mem_wr_ack = ($urandom_range(0, 1) == 1);
            if (m_pending() > 0 && $urandom_range(0, 9) < ((i / 500) % 2 == 0 ? 5 : 1)) begin
                host_wp_we  = 1'b1;
                host_wp_val = PTR_W'(m_wp + 1);
            end else begin
                host_wp_we = 1'b0;
            end
            @(negedge clk);
        end
        evt_valid = 1'b0; host_wp_we = 1'b0; mem_wr_ack = 1'b1;
        repeat (3) @(negedge clk);

        chk(n_coincide > 0, "R7 same-edge pointer updates seen", n_coincide, 1);
        chk(n_full_seen > 0, "R3 full reached", n_full_seen, 1);
        finish_run();
    end

endmodule